// File: doc/BRIEF.md
# Source-Selecting Clock Divider with Gated Pre-Scaler

This block takes four candidate clocks, picks one according to a control register, and divides it down to a single output clock. Between the selector and the output sit two integer division stages. A coarse pre-scaler applies only when the highest-numbered source is selected. A fine post-scaler applies on every path. The total division therefore depends on which source is chosen. The block can only lower a frequency; it never raises one.

Software writes the 32-bit control word through a simple write strobe and reads it back at any time. A status output reports the effective total division ratio, so the integrator can see the resulting rate without decoding the register. A new ratio is loaded only at the end of an output period, so a change never produces a runt pulse.

Top module: `muxed_prediv_clkgen`

## Requirements
- R1: After reset the control word reads 0. This selects source 0 with both division fields at 0, and the ratio status reads 1.
- R2: All 32 control bits read back exactly as written. Bits outside 17:16, 12:8 and 5:4 change neither the status nor the output clock.
- R3: Control bits 17:16 choose which of the four source clocks (index 0 to 3) drives the dividers.
- R4: The post-scaler divides by the value of bits 5:4 plus one, giving a range of 1 to 4.
- R5: The pre-scaler divides by the value of bits 12:8 plus one, giving a range of 1 to 32. It is active only when bits 17:16 equal 3. For any other source, bits 12:8 are ignored.
- R6: The ratio status equals the post-scaler ratio times the pre-scaler ratio, with the pre-scaler counted only when it is active. Its range is 1 to 128.
- R7: When the total ratio is 1, the output follows the selected source clock unchanged.
- R8: When the total ratio N is greater than 1, each output period spans N rising edges of the selected source. The output is high for ceil(N/2) of them, starting at the period boundary.
- R9: A changed ratio takes effect only at the next output period boundary. The period in progress completes with its old high and low lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Active-low asynchronous reset for all state |
| src_clk | input | 4 | Candidate source clocks, index 0 to 3 |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word |
| ratio_o | output | 8 | Effective total division ratio |
| div_clk_o | output | 1 | Divided output clock |

## Verification
The embedded properties check the following on every edge. The period counter never reaches the active ratio. The active ratio changes only on a period wrap. The status stays within 1 to 128. A written word is read back on the next cycle. Only the bench scenarios can show the output waveform itself: period length and high time for each source, the pre-scaler being ignored off source 3, pass-through at ratio 1, and the old period finishing intact when the ratio is changed mid-period.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;
  parameter int DATA_W   = 32;
  parameter int NSRC     = 4;
  parameter int SEL_LSB  = 16;
  parameter int PRE_LSB  = 8;
  parameter int PRE_W    = 5;
  parameter int POST_LSB = 4;
  parameter int POST_W   = 2;
  parameter int PRE_SRC  = 3;

  localparam int SEL_W   = $clog2(NSRC);
  localparam int RATIO_W = PRE_W + POST_W + 1;
  localparam int MAX_RATIO = (1 << PRE_W) * (1 << POST_W);

  function automatic logic [SEL_W-1:0] get_sel(input logic [DATA_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction

  // Total division implied by a control word.
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic [DATA_W-1:0] w);
    logic [RATIO_W-1:0] pre_r;
    logic [RATIO_W-1:0] post_r;
    post_r = RATIO_W'(w[POST_LSB +: POST_W]) + 1'b1;
    if (get_sel(w) == SEL_W'(PRE_SRC))
      pre_r = RATIO_W'(w[PRE_LSB +: PRE_W]) + 1'b1;
    else
      pre_r = RATIO_W'(1);
    return RATIO_W'(pre_r * post_r);
  endfunction

  // High phase length: ceil(n/2).
  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] n);
    logic [RATIO_W:0] t;
    t = {1'b0, n} + 1'b1;
    return t[RATIO_W:1];
  endfunction
endpackage

// File: rtl/ckdiv_ctrl.sv
`timescale 1ns/1ps
module ckdiv_ctrl
  import ckdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [SEL_W-1:0]    sel,
  output logic [RATIO_W-1:0]  ratio
);
  logic [DATA_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign rdata = ctl_q;
  assign sel   = get_sel(ctl_q);
  assign ratio = eff_ratio(ctl_q);

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == $past(wdata))); // R2
  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != '0) && (int'(ratio) <= MAX_RATIO)); // R6
endmodule

// File: rtl/ckdiv_srcmux.sv
`timescale 1ns/1ps
module ckdiv_srcmux
  import ckdiv_pkg::*;
(
  input  logic [NSRC-1:0]  src_clk,
  input  logic [SEL_W-1:0] sel,
  output logic             mclk
);
  always_comb begin
    mclk = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel == SEL_W'(i)) mclk = src_clk[i];
  end
endmodule

// File: rtl/ckdiv_core.sv
`timescale 1ns/1ps
module ckdiv_core
  import ckdiv_pkg::*;
(
  input  logic               dclk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] cfg_ratio,
  output logic               div_clk
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] act_q;
  logic               lvl_q;
  logic [RATIO_W-1:0] cnt_nxt;
  logic               wrap;
  logic               bypass;

  assign wrap    = (cnt_q == act_q - 1'b1);
  assign cnt_nxt = cnt_q + 1'b1;
  assign bypass  = (act_q == RATIO_W'(1));

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RATIO_W'(1);
      lvl_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      act_q <= cfg_ratio;
      lvl_q <= (cfg_ratio != RATIO_W'(1));
    end else begin
      cnt_q <= cnt_nxt;
      lvl_q <= (cnt_nxt < high_len(act_q));
    end
  end

  assign div_clk = bypass ? dclk : lvl_q;

  AST_CNT_BOUND: assert property (@(posedge dclk) disable iff (!rst_n)
    cnt_q < act_q); // R8
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge dclk) disable iff (!rst_n)
    !$past(wrap) |-> $stable(act_q)); // R9
endmodule

// File: rtl/muxed_prediv_clkgen.sv
`timescale 1ns/1ps
module muxed_prediv_clkgen
  import ckdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_clk,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic                div_clk_o
);
  logic [SEL_W-1:0] sel;
  logic             mclk;

  ckdiv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel(sel), .ratio(ratio_o)
  );

  ckdiv_srcmux u_mux (.src_clk(src_clk), .sel(sel), .mclk(mclk));

  ckdiv_core u_core (
    .dclk(mclk), .rst_n(rst_n), .cfg_ratio(ratio_o), .div_clk(div_clk_o)
  );
endmodule

// File: tb/muxed_prediv_clkgen_bench.sv
`timescale 1ns/1ps
module muxed_prediv_clkgen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_clk = 4'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  ratio_o;
  logic        div_clk_o;

  int errors = 0;
  int checks = 0;
  int mon_sel = 0;
  logic mon_clk;
  bit   done = 1'b0;

  assign mon_clk = src_clk[mon_sel];

  muxed_prediv_clkgen u_muxed_prediv_clkgen (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ratio_o(ratio_o),
    .div_clk_o(div_clk_o)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;
  initial forever #5 src_clk[0] = ~src_clk[0];
  initial forever #7 src_clk[1] = ~src_clk[1];
  initial forever #3 src_clk[2] = ~src_clk[2];
  initial forever #2 src_clk[3] = ~src_clk[3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int s, input int pre, input int post);
    return (32'(s) << 16) | (32'(pre) << 8) | (32'(post) << 4);
  endfunction

  task automatic reg_write(input logic [31:0] w);
    @(negedge clk); reg_we = 1'b1; reg_wdata = w;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic sample(output logic v);
    @(posedge mon_clk); #1; v = div_clk_o;
  endtask

  task automatic settle(input int s);
    mon_sel = s;
    repeat (300) @(posedge mon_clk);
  endtask

  // Measures period and high time on the monitored source.
  task automatic check_wave(input int n, input string req);
    logic s [0:399];
    int r1, r2, hi;
    int k;
    k = 3*n + 4;
    for (int i = 0; i < k; i++) sample(s[i]);
    if (n == 1) begin
      int ones;
      ones = 0;
      for (int i = 0; i < k; i++) if (s[i]) ones++;
      chk(ones == k, req, ones, k);
      return;
    end
    r1 = -1; r2 = -1;
    for (int i = 1; i < k; i++)
      if (!s[i-1] && s[i]) begin
        if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
      end
    hi = 0;
    if (r1 >= 0) for (int i = r1; i < k && s[i]; i++) hi++;
    chk(r2 - r1 == n, {req, " period"}, r2 - r1, n);
    chk(hi == (n+1)/2, {req, " high"}, hi, (n+1)/2);
  endtask

  task automatic t_reset();
    chk(reg_rdata == 32'h0, "R1 reset word", int'(reg_rdata), 0);
    chk(ratio_o == 8'd1, "R1 reset ratio", int'(ratio_o), 1);
  endtask

  task automatic t_readback();
    reg_write(32'hA5C3_E07F);
    @(negedge clk);
    chk(reg_rdata == 32'hA5C3_E07F, "R2 readback", int'(reg_rdata), int'(32'hA5C3_E07F));
    // Fields: sel=3 (bits17:16), pre=0 (12:8), post=3 (5:4) -> 4
    chk(ratio_o == 8'd4, "R2 R6 status with junk bits", int'(ratio_o), 4);
    settle(3);
    check_wave(4, "R2 junk bits no effect");
  endtask

  task automatic t_post_src0();
    reg_write(word(0, 0, 1));
    settle(0);
    chk(ratio_o == 8'd2, "R4 status", int'(ratio_o), 2);
    check_wave(2, "R3 R4 src0 div2");
  endtask

  task automatic t_pre_ignored();
    reg_write(word(1, 7, 2));
    settle(1);
    chk(ratio_o == 8'd3, "R5 pre ignored status", int'(ratio_o), 3);
    check_wave(3, "R5 pre ignored src1");
  endtask

  task automatic t_pre_active();
    reg_write(word(3, 2, 1));
    settle(3);
    chk(ratio_o == 8'd6, "R6 status 3x2", int'(ratio_o), 6);
    check_wave(6, "R5 R8 src3 div6");
    reg_write(word(3, 4, 0));
    settle(3);
    chk(ratio_o == 8'd5, "R6 status 5x1", int'(ratio_o), 5);
    check_wave(5, "R8 odd ratio");
  endtask

  task automatic t_bypass();
    reg_write(word(2, 9, 0));
    settle(2);
    chk(ratio_o == 8'd1, "R7 status", int'(ratio_o), 1);
    check_wave(1, "R7 passthrough src2");
  endtask

  task automatic t_max();
    reg_write(word(3, 31, 3));
    settle(3);
    chk(ratio_o == 8'd128, "R6 max status", int'(ratio_o), 128);
    check_wave(128, "R8 max ratio");
  endtask

  task automatic t_boundary();
    logic prev, cur;
    logic s [0:19];
    reg_write(word(3, 7, 1));
    settle(3);
    prev = 1'b1;
    sample(cur);
    while (!(!prev && cur)) begin prev = cur; sample(cur); end
    fork
      reg_write(word(3, 0, 1));
      for (int i = 1; i < 20; i++) sample(s[i]);
    join
    for (int i = 1; i < 20; i++) begin
      logic e;
      if (i < 8) e = 1'b1;
      else if (i < 16) e = 1'b0;
      else e = ((i % 2) == 0);
      chk(s[i] == e, $sformatf("R9 sample %0d", i), int'(s[i]), int'(e));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_post_src0();
    t_pre_ignored();
    t_pre_active();
    t_bypass();
    t_max();
    t_boundary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule